// File: doc/BRIEF.md
# Receive Descriptor DMA Sequencer

This block is the control state machine of a descriptor-driven receive DMA engine. Software starts and stops it with single-cycle commands. While it runs, it fetches a receive descriptor through a request/acknowledge handshake. The acknowledge returns an ownership flag. With a descriptor that the DMA owns, the machine waits for an accepted frame and then follows the data beats of that frame. After the last beat it writes an optional timestamp and closes the descriptor, then fetches the next one. Memory traffic, the receive FIFO and frame filtering are handled by neighbouring logic. The sequencer only sequences them and reports what happened.

The machine reports its current state as a 3-bit code that a status register can show directly. It reports events as single-cycle pulses: frame complete, first buffer filled, no descriptor available, process stopped, and watchdog truncation. If the next descriptor is still owned by the host, the machine parks in a suspended state. It leaves that state on a poll demand or when the next accepted frame arrives. A frame that arrives while the machine is suspended or fetching is remembered, so that its transfer begins as soon as a usable descriptor is in hand.

Top module: `rxdma_seq`

## Requirements
- R1: `state_code` uses these codes: 000 stopped, 001 fetching descriptor, 011 waiting for a frame, 100 suspended, 101 closing descriptor, 110 timestamp write, 111 transferring frame data. Code 010 never appears.
- R2: In the stopped state, `start_cmd` moves the machine to fetching, and `desc_req` is high while fetching. A `desc_ack` with `desc_own_dma`=1 (the DMA owns the descriptor) moves the machine to waiting.
- R3: A `desc_ack` with `desc_own_dma`=0 moves the machine to suspended. `no_desc_evt` pulses only if the previously fetched descriptor was DMA-owned. Reset and stop clear that memory, so it then counts as "not DMA-owned".
- R4: In the suspended state, the machine stays put until `poll_demand` or `frame_arrive`, and either one moves it to fetching. A frame that arrives while the machine is suspended or fetching is remembered. After a DMA-owned fetch, the machine then passes through waiting for one cycle and starts the transfer without a new `frame_arrive`.
- R5: In the waiting state, `frame_arrive` moves the machine to transferring.
- R6: While transferring, the first `beat_valid` beat with `beat_buf_full`=1 pulses `early_rx_evt`. Later buffer-full beats of the same frame produce no pulse. A new frame may pulse again.
- R7: A beat with `beat_eof`=1 leads to the timestamp state for TS_CYC cycles when TS_EN=1, and otherwise straight to closing. Closing lasts CLOSE_CYC cycles. The machine then returns to fetching and `rx_done_evt` pulses in the same cycle.
- R8: `wdog_expired` while transferring truncates the frame. `wdog_evt` pulses, the machine goes directly to closing (no timestamp), and then it completes as in R7 with `rx_done_evt`.
- R9: `stop_cmd` in any non-stopped state moves the machine to stopped and pulses `stopped_evt`. Reset also pulses `stopped_evt` in the first cycle after release. A `stop_cmd` while already stopped gives no pulse. `stop_cmd` wins over `start_cmd` in the same cycle.
- R10: `frame_arrive` while stopped is ignored. The state stays 000, and after a later start and a DMA-owned fetch the machine stays in waiting.
- R11: Every event output is a registered single-cycle pulse that appears together with the state it leads to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Start receive process (pulse) |
| stop_cmd | input | 1 | Stop receive process (pulse) |
| poll_demand | input | 1 | Poll demand, resumes from suspend (pulse) |
| frame_arrive | input | 1 | An accepted frame is available (pulse) |
| desc_req | output | 1 | Descriptor fetch request, high while fetching |
| desc_ack | input | 1 | Descriptor fetch complete |
| desc_own_dma | input | 1 | Ownership flag of fetched descriptor, 1 = DMA |
| beat_valid | input | 1 | One data beat moved to host memory |
| beat_buf_full | input | 1 | This beat filled the first data buffer |
| beat_eof | input | 1 | This beat ends the frame |
| wdog_expired | input | 1 | Receive watchdog expired |
| state_code | output | 3 | Current state code (see R1) |
| rx_done_evt | output | 1 | Frame completed pulse |
| early_rx_evt | output | 1 | First buffer filled pulse |
| no_desc_evt | output | 1 | Descriptor unavailable pulse |
| stopped_evt | output | 1 | Process stopped pulse |
| wdog_evt | output | 1 | Watchdog truncation pulse |

## Verification
The embedded properties check on every cycle how the machine enters and leaves its states:
- each event pulse appears only together with the state it leads to, and only after the expected predecessor;
- a stopped or suspended machine does not move without its wake condition;
- a second early-receive pulse never occurs once the first one has fired in a frame.

Only the directed scenarios show the following:
- the exact duration of the timestamp and closing phases;
- the history-dependent suppression of `no_desc_evt` across repeated host-owned fetches and across a stop;
- the memory of a frame that arrives during suspend;
- the fact that a frame offered while stopped leaves no trace.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [2:0] {
        RXS_STOPPED = 3'b000,
        RXS_FETCH   = 3'b001,
        RXS_WAIT    = 3'b011,
        RXS_SUSPEND = 3'b100,
        RXS_CLOSE   = 3'b101,
        RXS_TSTAMP  = 3'b110,
        RXS_XFER    = 3'b111
    } rx_state_e;

    typedef struct packed {
        logic rx_done;
        logic early_rx;
        logic no_desc;
        logic stopped;
        logic wdog;
    } rx_evt_t;

    localparam rx_evt_t EVT_NONE = '{default: 1'b0};

    function automatic logic is_timed(rx_state_e s);
        return (s == RXS_CLOSE) || (s == RXS_TSTAMP);
    endfunction

    function automatic int unsigned phase_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/rxdma_phase_cnt.sv
module rxdma_phase_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == last);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= last)); // R7

endmodule

// File: rtl/rxdma_flags.sv
module rxdma_flags
    import rxdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_state_e state_q,
    input  logic      stop_cmd,
    input  logic      frame_arrive,
    input  logic      desc_ack,
    input  logic      desc_own_dma,
    input  logic      early_fire,
    output logic      pending_q,
    output logic      last_own_q,
    output logic      er_done_q
);
    // frame remembered while suspended / fetching / busy
    always_ff @(posedge clk) begin
        if (rst || stop_cmd || state_q == RXS_STOPPED) begin
            pending_q <= 1'b0;
        end else if (state_q == RXS_WAIT) begin
            pending_q <= 1'b0;
        end else if (frame_arrive) begin
            pending_q <= 1'b1;
        end
    end

    // ownership of the previously fetched descriptor
    always_ff @(posedge clk) begin
        if (rst || stop_cmd || state_q == RXS_STOPPED) begin
            last_own_q <= 1'b0;
        end else if (state_q == RXS_FETCH && desc_ack) begin
            last_own_q <= desc_own_dma;
        end
    end

    // early-receive already reported for the current frame
    always_ff @(posedge clk) begin
        if (rst || state_q != RXS_XFER) begin
            er_done_q <= 1'b0;
        end else if (early_fire) begin
            er_done_q <= 1'b1;
        end
    end

    AST_PEND_CLR_STOP: assert property (@(posedge clk) disable iff (rst)
        (state_q == RXS_STOPPED) |=> !pending_q); // R10

    AST_OWN_CLR_STOP: assert property (@(posedge clk) disable iff (rst)
        (state_q == RXS_STOPPED) |=> !last_own_q); // R3

endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm
    import rxdma_pkg::*;
#(
    parameter bit TS_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_cmd,
    input  logic      stop_cmd,
    input  logic      poll_demand,
    input  logic      frame_arrive,
    input  logic      desc_ack,
    input  logic      desc_own_dma,
    input  logic      beat_valid,
    input  logic      beat_buf_full,
    input  logic      beat_eof,
    input  logic      wdog_expired,
    input  logic      pending_q,
    input  logic      last_own_q,
    input  logic      er_done_q,
    input  logic      phase_done,
    output rx_state_e state_q,
    output logic      leave,
    output logic      early_fire,
    output rx_evt_t   evt_q
);
    localparam rx_state_e EOF_NEXT = TS_EN ? RXS_TSTAMP : RXS_CLOSE;

    rx_state_e state_d;
    rx_evt_t   evt_d;

    always_comb begin
        state_d    = state_q;
        evt_d      = EVT_NONE;
        early_fire = 1'b0;
        if (stop_cmd) begin
            if (state_q != RXS_STOPPED) begin
                state_d       = RXS_STOPPED;
                evt_d.stopped = 1'b1;
            end
        end else begin
            unique case (state_q)
                RXS_STOPPED: begin
                    if (start_cmd) state_d = RXS_FETCH;
                end
                RXS_FETCH: begin
                    if (desc_ack) begin
                        if (desc_own_dma) begin
                            state_d = RXS_WAIT;
                        end else begin
                            state_d       = RXS_SUSPEND;
                            evt_d.no_desc = last_own_q;
                        end
                    end
                end
                RXS_WAIT: begin
                    if (frame_arrive || pending_q) state_d = RXS_XFER;
                end
                RXS_SUSPEND: begin
                    if (poll_demand || frame_arrive) state_d = RXS_FETCH;
                end
                RXS_XFER: begin
                    if (wdog_expired) begin
                        state_d    = RXS_CLOSE;
                        evt_d.wdog = 1'b1;
                    end else if (beat_valid) begin
                        if (beat_buf_full && !er_done_q) begin
                            early_fire     = 1'b1;
                            evt_d.early_rx = 1'b1;
                        end
                        if (beat_eof) state_d = EOF_NEXT;
                    end
                end
                RXS_TSTAMP: begin
                    if (phase_done) state_d = RXS_CLOSE;
                end
                RXS_CLOSE: begin
                    if (phase_done) begin
                        state_d       = RXS_FETCH;
                        evt_d.rx_done = 1'b1;
                    end
                end
                default: state_d = RXS_STOPPED;
            endcase
        end
    end

    assign leave = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RXS_STOPPED;
            evt_q   <= '{stopped: 1'b1, default: 1'b0};
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
        end
    end

    AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == RXS_WAIT) |-> ($past(state_q) == RXS_FETCH || $past(state_q) == RXS_WAIT)); // R2

    AST_NODESC_ENTRY: assert property (@(posedge clk) disable iff (rst)
        evt_q.no_desc |-> (state_q == RXS_SUSPEND && $past(last_own_q))); // R3

    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == RXS_SUSPEND && !poll_demand && !frame_arrive && !stop_cmd)
        |=> (state_q == RXS_SUSPEND)); // R4

    AST_EARLY_ONCE: assert property (@(posedge clk) disable iff (rst)
        (er_done_q && state_q == RXS_XFER) |=> !evt_q.early_rx); // R6

    AST_DONE_FROM_CLOSE: assert property (@(posedge clk) disable iff (rst)
        evt_q.rx_done |-> (state_q == RXS_FETCH && $past(state_q) == RXS_CLOSE)); // R7

    AST_WDOG_TRUNC: assert property (@(posedge clk) disable iff (rst)
        evt_q.wdog |-> (state_q == RXS_CLOSE && $past(state_q) == RXS_XFER)); // R8

    AST_STOP_EVT: assert property (@(posedge clk) disable iff (rst)
        evt_q.stopped |-> (state_q == RXS_STOPPED)); // R9

    AST_STOPPED_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (state_q == RXS_STOPPED && !start_cmd) |=> (state_q == RXS_STOPPED)); // R10

    AST_NODESC_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_q.no_desc |=> !evt_q.no_desc); // R11

endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
    import rxdma_pkg::*;
#(
    parameter bit          TS_EN     = 1'b1,
    parameter int unsigned TS_CYC    = 2,
    parameter int unsigned CLOSE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_cmd,
    input  logic       stop_cmd,
    input  logic       poll_demand,
    input  logic       frame_arrive,
    output logic       desc_req,
    input  logic       desc_ack,
    input  logic       desc_own_dma,
    input  logic       beat_valid,
    input  logic       beat_buf_full,
    input  logic       beat_eof,
    input  logic       wdog_expired,
    output logic [2:0] state_code,
    output logic       rx_done_evt,
    output logic       early_rx_evt,
    output logic       no_desc_evt,
    output logic       stopped_evt,
    output logic       wdog_evt
);
    localparam int unsigned CNT_W = phase_width(TS_CYC, CLOSE_CYC);
    localparam logic [CNT_W-1:0] CLOSE_LAST = CNT_W'(CLOSE_CYC - 1);

    rx_state_e        state_q;
    rx_evt_t          evt_q;
    logic             leave, early_fire, phase_done;
    logic             pending_q, last_own_q, er_done_q;
    logic [CNT_W-1:0] phase_last;

    generate
        if (TS_EN) begin : g_ts
            localparam logic [CNT_W-1:0] TS_LAST = CNT_W'(TS_CYC - 1);
            assign phase_last = (state_q == RXS_TSTAMP) ? TS_LAST : CLOSE_LAST;
        end else begin : g_nots
            assign phase_last = CLOSE_LAST;
        end
    endgenerate

    rxdma_fsm #(.TS_EN(TS_EN)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_cmd    (start_cmd),
        .stop_cmd     (stop_cmd),
        .poll_demand  (poll_demand),
        .frame_arrive (frame_arrive),
        .desc_ack     (desc_ack),
        .desc_own_dma (desc_own_dma),
        .beat_valid   (beat_valid),
        .beat_buf_full(beat_buf_full),
        .beat_eof     (beat_eof),
        .wdog_expired (wdog_expired),
        .pending_q    (pending_q),
        .last_own_q   (last_own_q),
        .er_done_q    (er_done_q),
        .phase_done   (phase_done),
        .state_q      (state_q),
        .leave        (leave),
        .early_fire   (early_fire),
        .evt_q        (evt_q)
    );

    rxdma_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .state_q      (state_q),
        .stop_cmd     (stop_cmd),
        .frame_arrive (frame_arrive),
        .desc_ack     (desc_ack),
        .desc_own_dma (desc_own_dma),
        .early_fire   (early_fire),
        .pending_q    (pending_q),
        .last_own_q   (last_own_q),
        .er_done_q    (er_done_q)
    );

    rxdma_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clear (leave),
        .run   (is_timed(state_q)),
        .last  (phase_last),
        .done  (phase_done)
    );

    assign desc_req     = (state_q == RXS_FETCH);
    assign state_code   = state_q;
    assign rx_done_evt  = evt_q.rx_done;
    assign early_rx_evt = evt_q.early_rx;
    assign no_desc_evt  = evt_q.no_desc;
    assign stopped_evt  = evt_q.stopped;
    assign wdog_evt     = evt_q.wdog;

    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (rst)
        state_code != 3'b010); // R1

    AST_REQ_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
        desc_req |-> (state_code == 3'b001)); // R2

endmodule

// File: tb/rxdma_seq_tb.sv
module rxdma_seq_tb;
    logic       clk = 1'b0;
    logic       rst, start_cmd, stop_cmd, poll_demand, frame_arrive;
    logic       desc_req, desc_ack, desc_own_dma;
    logic       beat_valid, beat_buf_full, beat_eof, wdog_expired;
    logic [2:0] state_code;
    logic       rx_done_evt, early_rx_evt, no_desc_evt, stopped_evt, wdog_evt;

    int checks = 0;
    int errors = 0;
    bit saw_rsvd = 1'b0;

    always #10 clk = ~clk;

    rxdma_seq #(.TS_EN(1'b1), .TS_CYC(2), .CLOSE_CYC(2)) u_dut (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .poll_demand(poll_demand), .frame_arrive(frame_arrive),
        .desc_req(desc_req), .desc_ack(desc_ack), .desc_own_dma(desc_own_dma),
        .beat_valid(beat_valid), .beat_buf_full(beat_buf_full), .beat_eof(beat_eof),
        .wdog_expired(wdog_expired), .state_code(state_code),
        .rx_done_evt(rx_done_evt), .early_rx_evt(early_rx_evt),
        .no_desc_evt(no_desc_evt), .stopped_evt(stopped_evt), .wdog_evt(wdog_evt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (state_code == 3'b010) saw_rsvd = 1'b1;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start_cmd = 0; stop_cmd = 0; poll_demand = 0; frame_arrive = 0;
        desc_ack = 0; desc_own_dma = 0; beat_valid = 0; beat_buf_full = 0;
        beat_eof = 0; wdog_expired = 0;
        tick(); tick();
        rst = 1'b0;
        check("R9 reset state", state_code, 0);
        check("R9 stopped_evt after reset", stopped_evt, 1);
        tick();
        check("R11 stopped_evt single cycle", stopped_evt, 0);
    endtask

    task automatic t_stopped_ignore();
        frame_arrive = 1; tick(); frame_arrive = 0;
        check("R10 frame while stopped ignored", state_code, 0);
        start_cmd = 1; tick(); start_cmd = 0;
        check("R2 start enters fetch", state_code, 1);
        check("R2 desc_req while fetching", desc_req, 1);
        desc_ack = 1; desc_own_dma = 1; tick(); desc_ack = 0;
        check("R2 dma-owned to wait", state_code, 3);
        check("R3 no pulse on owned", no_desc_evt, 0);
        tick(); tick();
        check("R10 old frame not remembered", state_code, 3);
    endtask

    task automatic t_frame();
        frame_arrive = 1; tick(); frame_arrive = 0;
        check("R5 frame starts transfer", state_code, 7);
        beat_valid = 1; tick();
        check("R6 plain beat no early", early_rx_evt, 0);
        beat_buf_full = 1; tick();
        check("R6 early on first buffer", early_rx_evt, 1);
        tick();
        check("R6 early only once", early_rx_evt, 0);
        beat_buf_full = 0; beat_eof = 1; tick(); beat_valid = 0; beat_eof = 0;
        check("R7 eof to timestamp", state_code, 6);
        tick();
        check("R7 timestamp 2nd cycle", state_code, 6);
        tick();
        check("R7 close entered", state_code, 5);
        tick();
        check("R7 close 2nd cycle no done", rx_done_evt, 0);
        tick();
        check("R7 back to fetch", state_code, 1);
        check("R7 rx_done pulse", rx_done_evt, 1);
        tick();
        check("R11 rx_done single cycle", rx_done_evt, 0);
    endtask

    task automatic t_suspend();
        desc_ack = 1; desc_own_dma = 0; tick(); desc_ack = 0;
        check("R3 host-owned suspends", state_code, 4);
        check("R3 no_desc after owned", no_desc_evt, 1);
        tick();
        check("R11 no_desc single cycle", no_desc_evt, 0);
        check("R4 suspend holds", state_code, 4);
        poll_demand = 1; tick(); poll_demand = 0;
        check("R4 poll refetches", state_code, 1);
        desc_ack = 1; desc_own_dma = 0; tick(); desc_ack = 0;
        check("R3 second host-owned no pulse", no_desc_evt, 0);
        frame_arrive = 1; tick(); frame_arrive = 0;
        check("R4 frame refetches", state_code, 1);
        desc_ack = 1; desc_own_dma = 1; tick(); desc_ack = 0;
        check("R4 owned to wait", state_code, 3);
        tick();
        check("R4 remembered frame transfers", state_code, 7);
    endtask

    task automatic t_wdog();
        wdog_expired = 1; tick(); wdog_expired = 0;
        check("R8 truncate to close", state_code, 5);
        check("R8 wdog pulse", wdog_evt, 1);
        tick();
        check("R8 wdog single cycle", wdog_evt, 0);
        tick();
        check("R8 truncated frame completes", rx_done_evt, 1);
    endtask

    task automatic t_second_frame();
        desc_ack = 1; desc_own_dma = 1; tick(); desc_ack = 0;
        frame_arrive = 1; tick(); frame_arrive = 0;
        beat_valid = 1; beat_buf_full = 1; tick();
        check("R6 early again on new frame", early_rx_evt, 1);
        beat_buf_full = 0; beat_eof = 1; tick(); beat_valid = 0; beat_eof = 0;
        check("R7 second eof to timestamp", state_code, 6);
    endtask

    task automatic t_stop();
        stop_cmd = 1; tick(); stop_cmd = 0;
        check("R9 stop enters stopped", state_code, 0);
        check("R9 stopped pulse", stopped_evt, 1);
        stop_cmd = 1; tick(); stop_cmd = 0;
        check("R9 stop while stopped no pulse", stopped_evt, 0);
        start_cmd = 1; stop_cmd = 1; tick(); start_cmd = 0; stop_cmd = 0;
        check("R9 stop beats start", state_code, 0);
        start_cmd = 1; tick(); start_cmd = 0;
        desc_ack = 1; desc_own_dma = 0; tick(); desc_ack = 0;
        check("R3 stop cleared ownership history", no_desc_evt, 0);
        check("R3 suspended after restart", state_code, 4);
    endtask

    initial begin
        t_reset();
        t_stopped_ignore();
        t_frame();
        t_suspend();
        t_wdog();
        t_second_frame();
        t_stop();
        check("R1 code 010 never seen", saw_rsvd, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule